// File: doc/BRIEF.md
# Power-State Controller with Interrupt Status

This block is the power-management register slice of a legacy I/O controller. It gathers interrupt events from two groups of sources, four peripheral devices and four auxiliary functions, into two sticky status registers. The host clears these registers by writing 1 to the bits it wants to clear. The same slice runs a two-state power machine, working and sleeping, together with a wake flag and a standby countdown timer.

While working, any source event reloads the standby timer from the programmed timeout. The timer counts down on each `tick` pulse, and when it runs out the machine goes to sleep. While sleeping, an event from a source whose resume-enable bit is set raises the wake flag and returns the machine to working on that same edge. The wake flag is cleared by a host write of 1 or, automatically, when the timer expires.

The host uses a flat port with address, write data, write strobe and read data. Reads are combinational from the address.

Top module: `pm_wake_ctrl`

## Requirements
- R1: A status bit in either interrupt register becomes 1 on the clock edge after its source event input is high. It stays 1 until the host writes 1 to that bit. Writing 0 to that bit leaves it unchanged.
- R2: In both interrupt registers (address 0 and address 1), bits 7 to 4 always read as 0, and writes to those bits have no effect.
- R3: At address 0, bit 3 reports the printer port (`dev_evt[3]`), bit 2 the floppy controller (`dev_evt[2]`), bit 1 UART A (`dev_evt[1]`) and bit 0 UART B (`dev_evt[0]`).
- R4: At address 1, bit 3 reports the hardware monitor (`fn_evt[3]`), bit 2 the watchdog (`fn_evt[2]`), bit 1 consumer IR (`fn_evt[1]`) and bit 0 MIDI (`fn_evt[0]`).
- R5: The wake flag is read at address 2, bit 1. It becomes 1 only when the machine is sleeping and a source with its resume-enable bit set has an event. `resume_en[3:0]` gates `dev_evt[3:0]` and `resume_en[7:4]` gates `fn_evt[3:0]`. A host write never sets the flag.
- R6: On the edge that sets the wake flag, the machine enters the working state.
- R7: The wake flag clears when the host writes 1 to address 2, bit 1. It also clears on the edge where the standby timer expires.
- R8: Address 2, bit 0 is read-only and gives the power state: 1 means working and 0 means sleeping. The `working` output has the same value. Address 2, bits 7 to 2 read as 0.
- R9: While working, any source event reloads the timer with `standby_timeout`, and each `tick` lowers it by one. The tick that takes it from 1 to 0 moves the machine to sleeping on that edge. With a timeout of N and no events, the Nth tick causes sleep.
- R10: If a source event and a host write of 1 hit the same status bit in the same cycle, the bit ends up 1.
- R11: Reset clears all status bits and the wake flag, selects the working state and loads the timer from `standby_timeout`. A timeout of 0 never lets the machine sleep.
- R12: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Standby timer count enable, one pulse per time unit |
| dev_evt | input | 4 | Peripheral device event pulses |
| fn_evt | input | 4 | Auxiliary function event pulses |
| resume_en | input | 8 | Per-source resume enables (7:4 functions, 3:0 devices) |
| standby_timeout | input | TW | Standby reload value, 0 disables sleep |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Host write data |
| reg_we | input | 1 | Host write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| working | output | 1 | Power state, 1 working and 0 sleeping |

## Verification
A corrupted status bit shows up in `reg_rdata` as soon as the host selects its address, one edge after the stimulus that caused it. A wrong timer count shows up as a change on `working` that comes one or more ticks too early or too late. A missed resume, or a wake flag that does not clear, is visible on the next read of address 2. The bench compares every output against its own model on every cycle, so any of these faults is caught on the cycle it first appears.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    localparam int SRC_W  = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int EN_W   = 2 * SRC_W;

    localparam logic [ADDR_W-1:0] ADDR_DEV = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FN  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PWR = 2'd2;

    localparam int PWR_STATE_BIT = 0;
    localparam int PWR_WAKE_BIT  = 1;

    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_WORK  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_wr_t;

    function automatic logic [SRC_W-1:0] w1c_bits(host_wr_t wr, logic [ADDR_W-1:0] target);
        return (wr.we && wr.addr == target) ? wr.data[SRC_W-1:0] : '0;
    endfunction

    function automatic logic wake_w1c(host_wr_t wr);
        return wr.we && wr.addr == ADDR_PWR && wr.data[PWR_WAKE_BIT];
    endfunction

    function automatic logic [DATA_W-1:0] pad_status(logic [SRC_W-1:0] sts);
        return {{(DATA_W-SRC_W){1'b0}}, sts};
    endfunction

endpackage

// File: rtl/pm_irq_status.sv
module pm_irq_status #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts[i] <= 1'b0;
            else if (evt[i])
                sts[i] <= 1'b1;
            else if (clr[i])
                sts[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pm_standby_timer.sv
module pm_standby_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          working,
    input  logic          any_evt,
    input  logic          wake_go,
    input  logic          tick,
    input  logic [TW-1:0] timeout,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;

    assign expire = working && tick && !any_evt && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= timeout;
        else if ((working && any_evt) || wake_go)
            cnt <= timeout;
        else if (working && tick && cnt != '0)
            cnt <= cnt - ONE;
    end
endmodule

// File: rtl/pm_power_fsm.sv
module pm_power_fsm
    import pm_wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic resume_hit,
    input  logic expire,
    input  logic wake_clr,
    output logic wake_go,
    output logic working,
    output logic wake_sts
);
    pwr_state_e state, state_n;
    logic       wake_n;

    assign wake_go = (state == PWR_SLEEP) && resume_hit;
    assign working = (state == PWR_WORK);

    always_comb begin
        state_n = state;
        wake_n  = wake_sts;
        unique case (state)
            PWR_SLEEP: if (resume_hit) state_n = PWR_WORK;
            PWR_WORK:  if (expire)     state_n = PWR_SLEEP;
            default:   state_n = PWR_WORK;
        endcase
        if (wake_go)
            wake_n = 1'b1;
        else if (wake_clr || expire)
            wake_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PWR_WORK;
            wake_sts <= 1'b0;
        end else begin
            state    <= state_n;
            wake_sts <= wake_n;
        end
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [SRC_W-1:0]  dev_evt,
    input  logic [SRC_W-1:0]  fn_evt,
    input  logic [EN_W-1:0]   resume_en,
    input  logic [TW-1:0]     standby_timeout,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              working
);
    host_wr_t        wr;
    logic [SRC_W-1:0] dev_sts, fn_sts;
    logic [EN_W-1:0]  all_evt;
    logic            any_evt, resume_hit, expire, wake_go, wake_sts;

    assign wr         = '{we: reg_we, addr: reg_addr, data: reg_wdata};
    assign all_evt    = {fn_evt, dev_evt};
    assign any_evt    = |all_evt;
    assign resume_hit = |(all_evt & resume_en);

    pm_irq_status #(.W(SRC_W)) u_dev_sts (
        .clk (clk),
        .rst (rst),
        .evt (dev_evt),
        .clr (w1c_bits(wr, ADDR_DEV)),
        .sts (dev_sts)
    );

    pm_irq_status #(.W(SRC_W)) u_fn_sts (
        .clk (clk),
        .rst (rst),
        .evt (fn_evt),
        .clr (w1c_bits(wr, ADDR_FN)),
        .sts (fn_sts)
    );

    pm_standby_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .working (working),
        .any_evt (any_evt),
        .wake_go (wake_go),
        .tick    (tick),
        .timeout (standby_timeout),
        .expire  (expire)
    );

    pm_power_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .resume_hit (resume_hit),
        .expire     (expire),
        .wake_clr   (wake_w1c(wr)),
        .wake_go    (wake_go),
        .working    (working),
        .wake_sts   (wake_sts)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DEV: reg_rdata = pad_status(dev_sts);
            ADDR_FN:  reg_rdata = pad_status(fn_sts);
            ADDR_PWR: begin
                reg_rdata[PWR_STATE_BIT] = working;
                reg_rdata[PWR_WAKE_BIT]  = wake_sts;
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pm_wake_ctrl_chk.sv
module pm_wake_ctrl_chk
    import pm_wake_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SRC_W-1:0]  dev_evt,
    input logic [SRC_W-1:0]  fn_evt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              working,
    input logic [SRC_W-1:0]  dev_sts,
    input logic [SRC_W-1:0]  fn_sts,
    input logic              wake_sts
);
    // R1 / R10: an event always leaves its bit set
    p_evt_latch_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((dev_sts & $past(dev_evt)) == $past(dev_evt)) &&
                  ((fn_sts & $past(fn_evt)) == $past(fn_evt))));

    // R1: no bit rises without its event
    p_no_spont_set_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((dev_sts & ~$past(dev_sts) & ~$past(dev_evt)) == '0) &&
                  ((fn_sts & ~$past(fn_sts) & ~$past(fn_evt)) == '0)));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != ADDR_PWR) |-> (reg_rdata[DATA_W-1:SRC_W] == '0));

    p_wake_from_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_sts) |-> !$past(working));

    p_wake_to_work_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_sts) |-> working);

    p_sleep_clears_wake_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(working) |-> !wake_sts);

    p_state_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_PWR) |-> (reg_rdata[PWR_STATE_BIT] == working));
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dev_evt   (dev_evt),
    .fn_evt    (fn_evt),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .working   (working),
    .dev_sts   (dev_sts),
    .fn_sts    (fn_sts),
    .wake_sts  (wake_sts)
);

// File: tb/pm_wake_ctrl_test.sv
module pm_wake_ctrl_test;
    localparam int TW = 8;
    localparam int MAX_CYC = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [3:0]    dev_evt = '0, fn_evt = '0;
    logic [7:0]    resume_en = '0;
    logic [TW-1:0] standby_timeout = '0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic          working;

    int n_run = 0, n_fail = 0;
    logic [3:0]    m_dev, m_fn;
    logic          m_wake, m_work;
    logic [TW-1:0] m_cnt;

    always #10 clk = ~clk;

    pm_wake_ctrl #(.TW(TW)) uut (
        .clk(clk), .rst(rst), .tick(tick), .dev_evt(dev_evt), .fn_evt(fn_evt),
        .resume_en(resume_en), .standby_timeout(standby_timeout),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .working(working)
    );

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {4'h0, m_dev};
            2'd1: return {4'h0, m_fn};
            2'd2: return {6'h0, m_wake, m_work};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic step(input logic [3:0] d, input logic [3:0] f, input logic t,
                        input logic we, input logic [1:0] a, input logic [7:0] wd);
        logic [7:0] all, cd, cf;
        logic any, hit, exp_x, n_wake, n_work;
        logic [TW-1:0] n_cnt;
        dev_evt = d; fn_evt = f; tick = t; reg_we = we; reg_addr = a; reg_wdata = wd;
        all = {f, d};
        any = |all;
        hit = |(all & resume_en);
        cd = (we && a == 2'd0) ? wd : 8'h0;
        cf = (we && a == 2'd1) ? wd : 8'h0;
        n_wake = m_wake; n_work = m_work; n_cnt = m_cnt;
        exp_x = 1'b0;
        if (!m_work) begin
            if (hit) begin n_work = 1'b1; n_cnt = standby_timeout; end
        end else begin
            exp_x = t && !any && m_cnt == TW'(1);
            if (any) n_cnt = standby_timeout;
            else if (t && m_cnt != '0) n_cnt = m_cnt - TW'(1);
            if (exp_x) n_work = 1'b0;
        end
        if (!m_work && hit) n_wake = 1'b1;
        else if ((we && a == 2'd2 && wd[1]) || exp_x) n_wake = 1'b0;
        @(posedge clk);
        m_dev = (m_dev & ~cd[3:0]) | d;
        m_fn  = (m_fn & ~cf[3:0]) | f;
        m_wake = n_wake; m_work = n_work; m_cnt = n_cnt;
        @(negedge clk);
        case (a)
            2'd0: check("R3 model addr0", {24'h0, reg_rdata}, {24'h0, exp_read(a)});
            2'd1: check("R4 model addr1", {24'h0, reg_rdata}, {24'h0, exp_read(a)});
            2'd2: check("R8 model addr2", {24'h0, reg_rdata}, {24'h0, exp_read(a)});
            default: check("R12 model addr3", {24'h0, reg_rdata}, 32'h0);
        endcase
        check("R9 working", {31'h0, working}, {31'h0, m_work});
    endtask

    task automatic idle(input logic [1:0] a);
        step(4'h0, 4'h0, 1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic do_reset(input logic [TW-1:0] tmo, input logic [7:0] en);
        @(negedge clk);
        rst = 1'b1; standby_timeout = tmo; resume_en = en;
        dev_evt = '0; fn_evt = '0; tick = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_dev = '0; m_fn = '0; m_wake = 1'b0; m_work = 1'b1; m_cnt = tmo;
    endtask

    initial begin
        #(20 * MAX_CYC);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // R11 reset state
        do_reset(8'd3, 8'h01);
        idle(2'd0); check("R11 reset dev", {24'h0, reg_rdata}, 32'h00);
        idle(2'd1); check("R11 reset fn", {24'h0, reg_rdata}, 32'h00);
        idle(2'd2); check("R11 reset pwr", {24'h0, reg_rdata}, 32'h01);

        // R3 / R4 bit maps
        step(4'h8, 4'h0, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R3 printer bit3", {24'h0, reg_rdata}, 32'h08);
        step(4'h0, 4'h4, 1'b0, 1'b0, 2'd1, 8'h00);
        check("R4 watchdog bit2", {24'h0, reg_rdata}, 32'h04);

        // R1 write 0 keeps, write 1 clears
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd0, 8'h00);
        check("R1 write0 keeps", {24'h0, reg_rdata}, 32'h08);
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd0, 8'h08);
        check("R1 write1 clears", {24'h0, reg_rdata}, 32'h00);

        // R2 reserved bits
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd1, 8'hF0);
        check("R2 reserved ignored", {24'h0, reg_rdata}, 32'h04);

        // R10 set beats clear
        step(4'h2, 4'h0, 1'b0, 1'b1, 2'd0, 8'h02);
        check("R10 set wins", {24'h0, reg_rdata}, 32'h02);

        // R12 address 3
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd3, 8'hFF);
        check("R12 addr3 zero", {24'h0, reg_rdata}, 32'h00);

        // R9 sleep after 3 ticks from the last event
        step(4'h1, 4'h0, 1'b0, 1'b0, 2'd2, 8'h00);
        step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        check("R9 awake before last tick", {31'h0, working}, 32'h1);
        step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        check("R9 asleep after third tick", {31'h0, working}, 32'h0);

        // R5 / R8 host write cannot set wake or state
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd2, 8'hFF);
        check("R5 write no wake", {24'h0, reg_rdata}, 32'h00);
        // R5 non-enabled source does not wake
        step(4'h0, 4'h2, 1'b0, 1'b0, 2'd2, 8'h00);
        check("R5 disabled source", {24'h0, reg_rdata}, 32'h00);
        // R6 enabled source wakes
        step(4'h1, 4'h0, 1'b0, 1'b0, 2'd2, 8'h00);
        check("R6 wake and work", {24'h0, reg_rdata}, 32'h03);
        // R7 host clear
        step(4'h0, 4'h0, 1'b0, 1'b1, 2'd2, 8'h02);
        check("R7 host clears wake", {24'h0, reg_rdata}, 32'h01);
        // R7 expiry clears wake
        repeat (3) step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        step(4'h1, 4'h0, 1'b0, 1'b0, 2'd2, 8'h00);
        check("R7 rewake", {24'h0, reg_rdata}, 32'h03);
        repeat (3) step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        check("R7 expiry clears wake", {24'h0, reg_rdata}, 32'h00);

        // R11 timeout zero never sleeps
        do_reset(8'd0, 8'hFF);
        repeat (50) step(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 8'h00);
        check("R11 zero timeout", {31'h0, working}, 32'h1);

        // random phases
        for (int ph = 0; ph < 6; ph++) begin
            do_reset(TW'($urandom_range(0, 6)), 8'($urandom));
            for (int c = 0; c < 3000; c++) begin
                logic [3:0] d, f;
                d = '0; f = '0;
                for (int b = 0; b < 4; b++) begin
                    d[b] = ($urandom_range(0, 40) == 0);
                    f[b] = ($urandom_range(0, 40) == 0);
                end
                step(d, f, 1'($urandom), ($urandom_range(0, 3) == 0),
                     2'($urandom), 8'($urandom));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule